// File: doc/BRIEF.md
# Amplified channel trigger controller

This block sits beside one differential amplifier channel that feeds an ADC. It holds the 8-bit control word for that channel: an enable, an input short-circuit, a 2-bit gain code and a 2-bit trigger source code. From that word it drives the amplifier's shunt and gain pins and produces a one-cycle conversion-start pulse.

The start pulse can come from an internal tick that fires once every eight ADC clocks. It can also come from the rising edge of one of three external synchronisation events. The ADC reports back with a busy level and a one-cycle done pulse.

Two rules protect the conversion. First, a software disable that arrives during a conversion does not take effect until that conversion reports done. Second, after any write that changes the gain, all starts are held back for four amplifier synchronisation periods, so that the amplifier can settle. A start request that arrives at a blocked moment is discarded, not saved for later.

Top module: `amp_trig_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, and `amp_en`, `amp_shunt`, `amp_gain` and `trig_out` are all 0.
- R2: A write stores `wr_data` into the control word. The layout is bit 7 enable, bit 6 shunt, bits 5:4 gain code and bits 1:0 trigger source. Bits 3:2 always read 0. The new word is visible on `rd_data` in the cycle after the write edge. With no conversion busy, `amp_en` equals the written enable bit in that same cycle.
- R3: `amp_gain` carries the stored gain code. Code g selects an amplification of 5·2^g, so 00, 01, 10 and 11 give 5, 10, 20 and 40.
- R4: `amp_shunt` equals the stored shunt bit (bit 6).
- R5: With trigger source 00 and the channel enabled and idle, `trig_out` pulses for one cycle exactly every 8 clocks.
- R6: With trigger source 01, 10 or 11, a rising edge on `evt_in[0]`, `evt_in[1]` or `evt_in[2]` respectively gives a `trig_out` pulse in the next cycle. A level held high gives only one pulse, and the two unselected event inputs have no effect.
- R7: A write with bit 7 = 0 stores trigger source 00, whatever bits 1:0 carry.
- R8: If the enable bit is cleared while `conv_busy` is high, `amp_en` stays 1 through the cycle that carries `conv_done`. It drops to 0 in the cycle after that.
- R9: A write whose gain code differs from the stored code blocks triggers for 32 clocks. An event sampled at the 32nd edge after the write is dropped, and one sampled at the 33rd edge fires. A write that keeps the same gain code opens no window.
- R10: A trigger request that comes while `conv_busy` is high is dropped, and no pulse follows when busy falls.
- R11: `trig_out` is never high unless `amp_en` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Stored control word |
| evt_in | input | 3 | External synchronisation event inputs |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| amp_en | output | 1 | Effective amplifier enable |
| amp_shunt | output | 1 | Amplifier input short-circuit |
| amp_gain | output | 2 | Gain code to the amplifier |
| trig_out | output | 1 | One-cycle conversion start pulse |

## Verification
A stored field that is corrupted shows on `rd_data`, `amp_gain` or `amp_shunt` one cycle after the write that set it. A fault in the deferred-enable state shows as `amp_en` dropping during a busy conversion, or staying high after done.

A divider phase or length error changes the spacing of `trig_out` pulses within one 8-cycle period. A settle counter that loads the wrong length or misses a gain change moves the first allowed trigger away from the 33rd edge after the write. The bench probes exactly that edge and the one before it.

// File: rtl/amp_trig_pkg.sv
package amp_trig_pkg;

  typedef struct packed {
    logic       en;
    logic       shunt;
    logic [1:0] gain;
    logic [1:0] tsel;
  } amp_ctrl_t;

  // Written word to stored fields; a disable write disarms the source.
  function automatic amp_ctrl_t decode_write(input logic [7:0] d);
    amp_ctrl_t c;
    c.en    = d[7];
    c.shunt = d[6];
    c.gain  = d[5:4];
    c.tsel  = d[7] ? d[1:0] : 2'b00;
    return c;
  endfunction

  function automatic logic [7:0] encode_read(input amp_ctrl_t c);
    return {c.en, c.shunt, c.gain, 2'b00, c.tsel};
  endfunction

  // Effective enable: follows software, but holds through a running conversion.
  function automatic logic hold_enable(input logic sw_en, input logic eff_q,
                                       input logic busy, input logic done);
    return sw_en | (eff_q & busy & ~done);
  endfunction

endpackage

// File: rtl/amp_ctrl_reg.sv
module amp_ctrl_reg
  import amp_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       conv_busy,
  input  logic       conv_done,
  output amp_ctrl_t  ctrl,
  output logic       eff_en,
  output logic       gain_chg
);
  amp_ctrl_t ctrl_q, ctrl_d;
  logic      eff_q;

  assign ctrl_d   = wr_en ? decode_write(wr_data) : ctrl_q;
  assign gain_chg = wr_en & (wr_data[5:4] != ctrl_q.gain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      eff_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      eff_q  <= hold_enable(ctrl_d.en, eff_q, conv_busy, conv_done);
    end
  end

  assign ctrl   = ctrl_q;
  assign eff_en = eff_q;
endmodule

// File: rtl/amp_tick_div.sv
module amp_tick_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/amp_settle.sv
module amp_settle #(
  parameter int CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gain_chg,
  output logic settling
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LOAD = W'(CYC);

  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (gain_chg)      left_q <= LOAD;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign settling = (left_q != '0);
endmodule

// File: rtl/amp_trig_sel.sv
module amp_trig_sel #(
  parameter int N_EVT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             tick,
  input  logic [1:0]       tsel,
  input  logic             eff_en,
  input  logic             busy,
  input  logic             settling,
  output logic [N_EVT-1:0] evt_rise,
  output logic             fire,
  output logic             trig_out
);
  logic [N_EVT-1:0] evt_q;
  logic             src_hit;
  logic             trig_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= evt_in[i];
    end
    assign evt_rise[i] = evt_in[i] & ~evt_q[i];
  end

  always_comb begin
    unique case (tsel)
      2'b00:   src_hit = tick;
      2'b01:   src_hit = evt_rise[0];
      2'b10:   src_hit = evt_rise[1];
      default: src_hit = evt_rise[2];
    endcase
  end

  assign fire = src_hit & eff_en & ~busy & ~settling;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= fire;
  end

  assign trig_out = trig_q;
endmodule

// File: rtl/amp_trig_ctrl.sv
module amp_trig_ctrl
  import amp_trig_pkg::*;
#(
  parameter int SYNC_DIV       = 8,
  parameter int SETTLE_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [2:0] evt_in,
  input  logic       conv_busy,
  input  logic       conv_done,
  output logic       amp_en,
  output logic       amp_shunt,
  output logic [1:0] amp_gain,
  output logic       trig_out
);
  localparam int SETTLE_CYC = SYNC_DIV * SETTLE_PERIODS;
  localparam int N_EVT      = 3;

  amp_ctrl_t        ctrl;
  logic             eff_en;
  logic             gain_chg;
  logic             tick;
  logic             settling;
  logic             fire;
  logic [N_EVT-1:0] evt_rise;

  amp_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_busy(conv_busy), .conv_done(conv_done),
    .ctrl(ctrl), .eff_en(eff_en), .gain_chg(gain_chg)
  );

  amp_tick_div #(.DIV(SYNC_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  amp_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .gain_chg(gain_chg), .settling(settling)
  );

  amp_trig_sel #(.N_EVT(N_EVT)) u_sel (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick(tick),
    .tsel(ctrl.tsel), .eff_en(eff_en), .busy(conv_busy),
    .settling(settling), .evt_rise(evt_rise), .fire(fire),
    .trig_out(trig_out)
  );

  assign rd_data   = encode_read(ctrl);
  assign amp_en    = eff_en;
  assign amp_shunt = ctrl.shunt;
  assign amp_gain  = ctrl.gain;
endmodule

// File: rtl/amp_trig_chk.sv
module amp_trig_chk #(
  parameter int SETTLE_CYC = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_hi,
  input logic [1:0] rd_tsel,
  input logic       conv_busy,
  input logic       conv_done,
  input logic       amp_en,
  input logic       amp_shunt,
  input logic [1:0] amp_gain,
  input logic       trig_out,
  input logic       gain_chg
);
  localparam int W = $clog2(SETTLE_CYC + 1);
  logic [W-1:0] quiet_left;

  always_ff @(posedge clk) begin
    if (!rst_n)                 quiet_left <= '0;
    else if (gain_chg)          quiet_left <= W'(SETTLE_CYC);
    else if (quiet_left != '0)  quiet_left <= quiet_left - 1'b1;
  end

  AST_EN_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi[3]) |=> amp_en); // R2
  AST_GAIN_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (amp_gain == $past(wr_hi[1:0]))); // R3
  AST_SHUNT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (amp_shunt == $past(wr_hi[2]))); // R4
  AST_TSEL_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi[3]) |=> (rd_tsel == 2'b00)); // R7
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_en && conv_busy && !conv_done) |=> amp_en); // R8
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> ($past(quiet_left) == '0)); // R9
  AST_NO_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> !$past(conv_busy)); // R10
  AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(amp_en)); // R11
endmodule

bind amp_trig_ctrl amp_trig_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_data[7:4]),
  .rd_tsel(rd_data[1:0]), .conv_busy(conv_busy), .conv_done(conv_done),
  .amp_en(amp_en), .amp_shunt(amp_shunt), .amp_gain(amp_gain),
  .trig_out(trig_out), .gain_chg(gain_chg)
);

// File: tb/amp_trig_ctrl_test.sv
module amp_trig_ctrl_test;
  localparam int DIV    = 8;
  localparam int SETTLE = DIV * 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] evt_in = '0;
  logic       conv_busy = 1'b0;
  logic       conv_done = 1'b0;
  logic       amp_en, amp_shunt, trig_out;
  logic [1:0] amp_gain;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  amp_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .conv_busy(conv_busy),
    .conv_done(conv_done), .amp_en(amp_en), .amp_shunt(amp_shunt),
    .amp_gain(amp_gain), .trig_out(trig_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [7:0] v);
    return v[7] ? {v[7:4], 2'b00, v[1:0]} : {1'b0, v[6:4], 4'b0000};
  endfunction

  // Leaves the caller at the falling edge just after the write edge.
  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Gain write, then an evt_in[0] rise sampled at the n-th edge after it.
  task automatic settle_probe(input logic [1:0] g, input int n, input logic expv);
    write_reg({2'b10, g, 4'b0001});
    repeat (n - 1) @(negedge clk);
    evt_in[0] = 1'b1;
    @(negedge clk);
    chk($sformatf("R9 gain=%0d edge=%0d", g, n), trig_out, expv);
    evt_in[0] = 1'b0;
    repeat (SETTLE + 4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int last, pulses;
    logic gap_ok, single_ok, prev;

    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 amp_en", amp_en, 0);
    chk("R1 trig_out", trig_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 amp_gain", amp_gain, 0);
    chk("R1 amp_shunt", amp_shunt, 0);

    // Full sweep of written words (R2, R3, R4, R7)
    for (int v = 0; v < 256; v++) begin
      write_reg(8'(v));
      chk($sformatf("R2 R7 word %02h", v), rd_data, exp_word(8'(v)));
      chk("R2 amp_en", amp_en, v[7]);
      chk("R4 shunt", amp_shunt, v[6]);
      chk($sformatf("R3 gain x%0d", 5 << v[5:4]), 5 << amp_gain, 5 << v[5:4]);
    end
    write_reg(8'h00);
    repeat (SETTLE + 4) @(negedge clk);

    // R5: internal tick source
    write_reg(8'h80);
    last = -1; pulses = 0; gap_ok = 1'b1; single_ok = 1'b1; prev = 1'b0;
    for (int c = 0; c < 8 * DIV; c++) begin
      @(negedge clk);
      if (trig_out) begin
        if (prev) single_ok = 1'b0;
        if (last >= 0 && c - last != DIV) gap_ok = 1'b0;
        last = c;
        pulses++;
      end
      prev = trig_out;
    end
    chk("R5 pulse count", pulses, 8);
    chk("R5 spacing", gap_ok, 1);
    chk("R5 single cycle", single_ok, 1);

    // R6: external event sources
    for (int s = 1; s < 4; s++) begin
      write_reg(8'h80 | 8'(s));
      for (int e = 0; e < 3; e++) begin
        evt_in[e] = 1'b1;
        @(negedge clk);
        chk($sformatf("R6 sel=%0d evt=%0d", s, e), trig_out, (e == s - 1));
        for (int h = 0; h < 4; h++) begin
          @(negedge clk);
          chk("R6 level held", trig_out, 0);
        end
        evt_in[e] = 1'b0;
        @(negedge clk);
      end
    end

    // R10: dropped while busy, not queued
    write_reg(8'h81);
    conv_busy = 1'b1;
    evt_in[0] = 1'b1;
    @(negedge clk);
    chk("R10 busy drop", trig_out, 0);
    conv_busy = 1'b0;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk("R10 not queued", trig_out, 0);
    end
    evt_in[0] = 1'b0;
    @(negedge clk);
    evt_in[0] = 1'b1;
    @(negedge clk);
    chk("R10 idle fires", trig_out, 1);
    evt_in[0] = 1'b0;
    @(negedge clk);

    // R9: settle window boundaries
    settle_probe(2'b01, SETTLE, 1'b0);
    settle_probe(2'b10, SETTLE + 1, 1'b1);
    settle_probe(2'b10, 1, 1'b1);
    settle_probe(2'b11, 1, 1'b0);

    // R8: deferred disable
    write_reg(8'hB0);
    conv_busy = 1'b1;
    write_reg(8'h03);
    chk("R8 held after clear", amp_en, 1);
    chk("R7 source disarmed", rd_data, 8'h00);
    for (int h = 0; h < 5; h++) begin
      @(negedge clk);
      chk("R8 held while busy", amp_en, 1);
    end
    conv_done = 1'b1;
    chk("R8 held in done cycle", amp_en, 1);
    @(negedge clk);
    conv_done = 1'b0;
    conv_busy = 1'b0;
    chk("R8 dropped after done", amp_en, 0);

    // R11: nothing fires while disabled
    pulses = 0;
    for (int c = 0; c < 3 * DIV; c++) begin
      evt_in = 3'(c);
      @(negedge clk);
      if (trig_out) pulses++;
    end
    chk("R11 no trigger when disabled", pulses, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule